// File: doc/BRIEF.md
# Line-rate subcarrier word receiver

This block listens to a serial control stream sent by an upstream video decoder and extracts a fresh subcarrier frequency word from each frame. Every frame has a fixed length of 67 bits, and each bit stays on the line for two clock cycles. A frame-start input marks the first cycle of bit 0. The receiver samples each bit once, in the second cycle of its two-cycle period. It keeps only the lowest 22 bits of the frame, which carry the frequency value. The remaining bits pass through untouched.

The captured word drives the oscillator increment for the next line, in place of the programmed frequency registers. Those registers are held at zero in this mode, so the received word alone sets the increment. Because a new word arrives once per line, the subcarrier follows line-length variations in the source.

A mode-enable input gates the whole receiver. A frame start that arrives partway through a frame throws away the partial frame and starts a new one.

Top module: `rtc_stream_rx`

## Requirements
- R1: While `rst` is high, `freq_valid` is 0 and `freq_word` is 0 from the next clock edge on.
- R2: With `mode_en` high, a frame start sampled at clock edge E begins a frame of 67 bits, two cycles per bit. `freq_valid` rises after edge E+133 and carries that frame's word.
- R3: The first bit received is frame bit 0. Frame bit k lands in `freq_word[k]` for k from 0 to 21, and frame bits 22 to 66 have no effect on the output.
- R4: Each bit is taken from the second cycle of its two-cycle period. The `ser_bit` value in the first cycle has no effect.
- R5: `freq_valid` is high for exactly one cycle per completed frame.
- R6: `freq_word` keeps its value in every cycle where `freq_valid` is low.
- R7: A frame start during a frame restarts reception at bit 0, and the partial frame produces no output. This includes a frame start in the cycle where the last bit would be sampled.
- R8: While `mode_en` is low, frame starts are ignored and any frame in progress is abandoned. No `freq_valid` pulse appears, and `freq_word` holds its value.
- R9: A frame start in the cycle straight after the final bit period is accepted, so frames can follow each other with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stream runs at half this rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_en | input | 1 | Enables line-locked reception |
| ser_bit | input | 1 | Serial stream data |
| frame_start | input | 1 | High in the first cycle of frame bit 0 |
| freq_word | output | 22 | Last captured subcarrier frequency word |
| freq_valid | output | 1 | One-cycle strobe when `freq_word` is updated |

## Verification
The hardest case to reach is a frame start that lands on the exact cycle where bit 66 would be sampled. There, the restart has to win over completion, and only a single cycle separates a discarded frame from a delivered one. The driver works at half-bit granularity, so it can cut a frame after any number of half periods: 133 half periods puts the new frame start on that sampling cycle. The same driver can drive the inverse value in the first half of every bit, which shows that only the second half is sampled. It can also drop the mode enable partway through a frame.

// File: rtl/rtc_rx_pkg.sv
`timescale 1ns/1ps
package rtc_rx_pkg;

    parameter int RTC_FRAME_BITS = 67;
    parameter int RTC_BIT_CYCLES = 2;
    parameter int RTC_WORD_BITS  = 22;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;

    // Per-cycle control decided by the frame sequencer
    typedef struct packed {
        logic restart;   // new frame accepted this cycle
        logic sample;    // take ser_bit this cycle
        logic done;      // this sample is the final bit of the frame
    } frame_ctl_t;

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rtc_bit_timer.sv
`timescale 1ns/1ps
module rtc_bit_timer
    import rtc_rx_pkg::*;
#(
    parameter int BIT_CYCLES = RTC_BIT_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PW = cnt_width(BIT_CYCLES);
    localparam logic [PW-1:0] LAST_PH  = PW'(BIT_CYCLES - 1);
    localparam logic [PW-1:0] AFTER_FS = PW'(1);

    logic [PW-1:0] phase_q;

    // phase_q holds the phase of the current cycle within its bit period;
    // the frame-start cycle itself is phase 0, so the next one is phase 1
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= AFTER_FS;
        end else if (run) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == LAST_PH);

endmodule

// File: rtl/rtc_frame_seq.sv
`timescale 1ns/1ps
module rtc_frame_seq
    import rtc_rx_pkg::*;
#(
    parameter int FRAME_BITS = RTC_FRAME_BITS,
    parameter int IDX_W      = cnt_width(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  logic             frame_start,
    input  logic             tick,
    output logic             active,
    output frame_ctl_t       ctl,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    rx_state_e        state_q;
    logic [IDX_W-1:0] idx_q;

    assign active  = (state_q == RX_RECV);
    assign bit_idx = idx_q;

    // A frame start always wins over sampling, so a restart on the
    // final sampling cycle discards the frame.
    always_comb begin
        ctl.restart = mode_en && frame_start;
        ctl.sample  = mode_en && active && tick && !frame_start;
        ctl.done    = ctl.sample && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
        end else if (!mode_en) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
        end else if (ctl.restart) begin
            state_q <= RX_RECV;
            idx_q   <= '0;
        end else if (ctl.sample) begin
            if (ctl.done) begin
                state_q <= RX_IDLE;
                idx_q   <= '0;
            end else begin
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_word_capture.sv
`timescale 1ns/1ps
module rtc_word_capture
    import rtc_rx_pkg::*;
#(
    parameter int WORD_BITS = RTC_WORD_BITS,
    parameter int IDX_W     = cnt_width(RTC_FRAME_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  frame_ctl_t           ctl,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic                 ser_bit,
    output logic [WORD_BITS-1:0] freq_word,
    output logic                 freq_valid
);
    logic [WORD_BITS-1:0] stage_q;
    logic [WORD_BITS-1:0] stage_next;

    // Each sampled bit goes straight to its own position; bits past the
    // word width match no lane and are dropped
    generate
        for (genvar i = 0; i < WORD_BITS; i++) begin : g_lane
            always_comb begin
                stage_next[i] = stage_q[i];
                if (ctl.sample && bit_idx == IDX_W'(i)) begin
                    stage_next[i] = ser_bit;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= '0;
            freq_word  <= '0;
            freq_valid <= 1'b0;
        end else begin
            freq_valid <= ctl.done;
            if (ctl.restart) begin
                stage_q <= '0;
            end else if (ctl.sample) begin
                stage_q <= stage_next;
            end
            if (ctl.done) begin
                freq_word <= stage_next;
            end
        end
    end

endmodule

// File: rtl/rtc_stream_rx.sv
`timescale 1ns/1ps
module rtc_stream_rx
    import rtc_rx_pkg::*;
#(
    parameter int FRAME_BITS = RTC_FRAME_BITS,
    parameter int BIT_CYCLES = RTC_BIT_CYCLES,
    parameter int WORD_BITS  = RTC_WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_en,
    input  logic                 ser_bit,
    input  logic                 frame_start,
    output logic [WORD_BITS-1:0] freq_word,
    output logic                 freq_valid
);
    localparam int IDX_W = cnt_width(FRAME_BITS);

    logic             active;
    logic             tick;
    frame_ctl_t       ctl;
    logic [IDX_W-1:0] bit_idx;

    rtc_bit_timer #(
        .BIT_CYCLES (BIT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.restart),
        .run     (active && mode_en),
        .tick    (tick)
    );

    rtc_frame_seq #(
        .FRAME_BITS (FRAME_BITS),
        .IDX_W      (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mode_en     (mode_en),
        .frame_start (frame_start),
        .tick        (tick),
        .active      (active),
        .ctl         (ctl),
        .bit_idx     (bit_idx)
    );

    rtc_word_capture #(
        .WORD_BITS (WORD_BITS),
        .IDX_W     (IDX_W)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .bit_idx    (bit_idx),
        .ser_bit    (ser_bit),
        .freq_word  (freq_word),
        .freq_valid (freq_valid)
    );

endmodule

// File: rtl/rtc_stream_rx_chk.sv
`timescale 1ns/1ps
module rtc_stream_rx_chk #(
    parameter int FRAME_BITS = 67,
    parameter int BIT_CYCLES = 2,
    parameter int WORD_BITS  = 22
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mode_en,
    input logic                 frame_start,
    input logic [WORD_BITS-1:0] freq_word,
    input logic                 freq_valid
);
    localparam int SPAN = FRAME_BITS * BIT_CYCLES - 1;
    localparam int CW   = $clog2(SPAN + 2);
    localparam logic [CW-1:0] SAT  = CW'(SPAN + 1);
    localparam logic [CW-1:0] GOAL = CW'(SPAN);

    // Edges since the latest accepted frame start, saturating
    logic [CW-1:0] since_fs;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_fs <= SAT;
        end else if (mode_en && frame_start) begin
            since_fs <= '0;
        end else if (since_fs != SAT) begin
            since_fs <= since_fs + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!freq_valid && freq_word == '0));

    assert_frame_length_R2: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> since_fs == GOAL);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        freq_valid |=> !freq_valid);

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !freq_valid |-> $stable(freq_word));

    assert_no_restart_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_en && frame_start) |=> !freq_valid);

    assert_mode_gate_R8: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> $past(mode_en));

endmodule

bind rtc_stream_rx rtc_stream_rx_chk #(
    .FRAME_BITS (FRAME_BITS),
    .BIT_CYCLES (BIT_CYCLES),
    .WORD_BITS  (WORD_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_en     (mode_en),
    .frame_start (frame_start),
    .freq_word   (freq_word),
    .freq_valid  (freq_valid)
);

// File: tb/tb_rtc_stream_rx.sv
`timescale 1ns/1ps
module tb_rtc_stream_rx;
    import rtc_rx_pkg::*;

    localparam int FB    = RTC_FRAME_BITS;
    localparam int BC    = RTC_BIT_CYCLES;
    localparam int WB    = RTC_WORD_BITS;
    localparam int FULL  = FB * BC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_en = 1'b0;
    logic          ser_bit = 1'b0;
    logic          frame_start = 1'b0;
    logic [WB-1:0] freq_word;
    logic          freq_valid;

    rtc_stream_rx dut (
        .clk         (clk),
        .rst         (rst),
        .mode_en     (mode_en),
        .ser_bit     (ser_bit),
        .frame_start (frame_start),
        .freq_word   (freq_word),
        .freq_valid  (freq_valid)
    );

    always #10 clk = ~clk;

    logic [WB-1:0] exp_q[$];
    int            checks = 0;
    int            errors = 0;
    int            n_valid = 0;
    int            n_pushed = 0;
    bit            prev_valid = 1'b0;
    bit            finished = 1'b0;
    logic [WB-1:0] exp_last = '0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design reports a word
    always @(negedge clk) begin
        if (!rst) begin
            if (freq_valid) begin
                n_valid++;
                check(!prev_valid, "R5 strobe longer than one cycle", 64'(prev_valid), 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R8 unexpected word", 64'(freq_word), 64'd0);
                end else begin
                    logic [WB-1:0] e;
                    e = exp_q.pop_front();
                    check(freq_word == e, "R2/R3 captured word", 64'(freq_word), 64'(e));
                end
            end
            prev_valid = freq_valid;
        end
    end

    // Driver: sends the given number of half-bit periods of a frame
    task automatic send_halves(input logic [WB-1:0] w, input int halves,
                               input bit glitch, input int drop_at,
                               input bit expect_out);
        logic [FB-1:0] fr;
        fr = {(FB-WB)'({$urandom(), $urandom()}), w};
        if (expect_out) begin
            exp_q.push_back(w);
            n_pushed++;
            exp_last = w;
        end
        for (int h = 0; h < halves; h++) begin
            int k;
            k = h / BC;
            @(negedge clk);
            frame_start = (h == 0);
            ser_bit = (glitch && (h % BC) != BC - 1) ? ~fr[k] : fr[k];
            if (drop_at >= 0 && h == drop_at) mode_en = 1'b0;
            if (drop_at >= 0 && h == drop_at + 4) mode_en = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [WB-1:0] w);
        send_halves(w, FULL, 1'b0, -1, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = 1'b0;
            ser_bit = 1'($urandom());
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int saved;
        repeat (5) @(negedge clk);
        check(freq_valid == 1'b0, "R1 reset strobe", 64'(freq_valid), 64'd0);
        check(freq_word == '0, "R1 reset word", 64'(freq_word), 64'd0);
        rst = 1'b0;
        mode_en = 1'b1;
        idle(4);

        // R2 R3: distinct bit patterns, separated by idle gaps
        send_frame(22'h155555); idle(7);
        send_frame(22'h2AAAAA); idle(3);
        send_frame(22'h000000); idle(5);
        send_frame(22'h3FFFFF); idle(2);
        send_frame(22'h000001); idle(2);
        send_frame(22'h200000); idle(6);
        check(freq_word == exp_last, "R6 hold after idle", 64'(freq_word), 64'(exp_last));

        // R9: back-to-back frames with no idle cycle
        for (int i = 0; i < 3; i++) send_frame(WB'($urandom()));
        idle(4);

        // R4: first half of every bit carries the inverse value
        send_halves(22'h0F0F0F, FULL, 1'b1, -1, 1'b1); idle(3);
        send_halves(WB'($urandom()), FULL, 1'b1, -1, 1'b1); idle(3);

        // R7: restart mid-frame, then on the final sampling cycle
        saved = n_valid;
        send_halves(22'h123456, 50, 1'b0, -1, 1'b0);
        check(n_valid == saved && freq_word == exp_last, "R7 partial frame dropped",
              64'(freq_word), 64'(exp_last));
        send_frame(22'h0ABCDE); idle(3);
        saved = n_valid;
        send_halves(22'h3C3C3C, FULL - 1, 1'b0, -1, 1'b0);
        send_frame(22'h111111); idle(3);
        check(n_valid == saved + 1, "R7 late restart yields one word",
              64'(n_valid - saved), 64'd1);

        // R8: disabled mode ignores a full frame
        saved = n_valid;
        mode_en = 1'b0;
        send_halves(22'h2D2D2D, FULL, 1'b0, -1, 1'b0); idle(6);
        check(n_valid == saved, "R8 no strobe while disabled", 64'(n_valid - saved), 64'd0);
        check(freq_word == exp_last, "R8 word held while disabled", 64'(freq_word), 64'(exp_last));
        mode_en = 1'b1;
        idle(2);

        // R8: enable dropped partway through a frame
        saved = n_valid;
        send_halves(22'h0C0FFE, FULL, 1'b0, 40, 1'b0); idle(6);
        check(n_valid == saved, "R8 frame abandoned on disable", 64'(n_valid - saved), 64'd0);
        check(freq_word == exp_last, "R8 word held after abandon", 64'(freq_word), 64'(exp_last));
        send_frame(22'h3A5A5A); idle(300);
        check(freq_word == exp_last, "R6 hold over long idle", 64'(freq_word), 64'(exp_last));

        check(exp_q.size() == 0, "R2 all expected words seen", 64'(exp_q.size()), 64'd0);
        check(n_valid == n_pushed, "R5 strobe count", 64'(n_valid), 64'(n_pushed));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule